// File: doc/BRIEF.md
# Triggered Trace Capture Buffer

This block records samples of a monitored data bus into on-chip memory. Everything runs on the clock of the logic being observed. A one-cycle arm pulse starts a capture. From then on, every cycle in which the storage-qualify input is high writes that cycle's data word into the next slot of a circular buffer. Cycles in which the qualify input is low write nothing and use up no slot.

The pre-trigger count is sampled at arm time. It sets how many qualified samples taken before the trigger are kept in the final window, so the trigger can fall on the first slot, on the last slot, or anywhere between them. Once the trigger has been seen, the block stores exactly enough further qualified samples to fill the window. It then raises its done flag and stops writing. If the trigger comes before the requested history has built up, it is still taken, and the window simply holds fewer pre-trigger samples.

When the capture is done, a plain address/data read port returns the window in time order. The trigger index output gives the window position of the trigger sample. The trigger and qualify inputs come from match logic outside this block, and the surrounding logic never needs to stall or reset.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, `capActive` and `capDone` are both low.
- R2: An arm pulse makes `capActive` high and `capDone` low in the next cycle. It restarts the capture with an empty history, and it discards any capture already in progress.
- R3: While capturing, a sample is written only in a cycle where `qualIn` is high. Unqualified cycles take no buffer slot.
- R4: The trigger is the first cycle after arming in which `trigIn` is high. With P = `preCount` sampled at arm time (0 to DEPTH-1), the window holds the last P qualified samples taken before the trigger cycle at read indices 0 to P-1, oldest first. Post-trigger samples follow them, starting at index P.
- R5: Qualified samples taken in and after the trigger cycle are post-trigger samples. After exactly DEPTH-P of them have been written, `capDone` is high from the next cycle on, `capActive` goes low, and no further sample changes the buffer until the next arm.
- R6: If fewer than P qualified samples come before the trigger, the trigger is still accepted. The window then has H pre-trigger samples, where H is the number collected, and DEPTH-H post-trigger samples.
- R7: Read index 0 returns the oldest sample of the window. Index i returns the i-th sample in time order, and `rdData` shows the sample one cycle after `rdAddr` is applied.
- R8: `trigIn` has no effect while the block is idle, and none after the first trigger of a capture.
- R9: Changing `preCount` while a capture runs does not change that capture.
- R10: When done, `trigIndex` gives the read index of the first post-trigger sample, min(P, H), and holds it until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitored user clock |
| rstN | input | 1 | Active-low synchronous reset |
| armPulse | input | 1 | Starts a new capture |
| trigIn | input | 1 | Trigger event from the match logic |
| qualIn | input | 1 | Storage-qualify flag for this cycle's sample |
| dataIn | input | DATA_W | Monitored data bus |
| preCount | input | IDX_W | Requested number of pre-trigger samples |
| rdAddr | input | IDX_W | Read index within the window, 0 = oldest |
| rdData | output | DATA_W | Sample at the index presented one cycle earlier |
| capActive | output | 1 | Capture in progress |
| capDone | output | 1 | Window complete |
| trigIndex | output | IDX_W | Read index of the trigger sample |

## Verification
The bench goes after the ends of the trigger-position range. With a pre-trigger count of zero, a design that lost the trigger-cycle sample or wrote one too many would shift the whole window. With a count of DEPTH-1, an off-by-one in the post counter would either finish with no post sample or overwrite the oldest pre sample. It also runs histories long enough to wrap the pointer several times, an early trigger that must report a short history, and a trigger that lands on an unqualified cycle, which a wrong design would store or count as a slot. After each window completes, more qualified data and stray triggers are fed in and the buffer is read again. A design that kept writing after done, or that re-armed on a late trigger, would show a changed window.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  // Strobes passed from the capture control to the storage datapath.
  typedef struct packed {
    logic clrPtr;  // restart the write pointer at slot 0
    logic wrEn;    // store dataIn at the current slot and advance
  } tcb_strobe_t;
endpackage

// File: rtl/tcb_ctrl.sv
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armPulse,
  input  logic             trigIn,
  input  logic             qualIn,
  input  logic [IDX_W-1:0] preCount,
  output tcb_strobe_t      strobe,
  output logic             capActive,
  output logic             capDone,
  output logic [IDX_W-1:0] trigIndex
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] FILL_MAX = '1;

  logic             active, done, triggered;
  logic [IDX_W-1:0] preReg;     // pre-trigger count latched at arm
  logic [IDX_W-1:0] fillCnt;    // qualified samples before trigger, saturating
  logic [CNT_W-1:0] postLeft;   // post-trigger samples still to store
  logic [IDX_W-1:0] trigIdxReg;

  logic             trigHit;
  logic [IDX_W-1:0] preEff;
  logic [CNT_W-1:0] postNeed;
  logic [CNT_W-1:0] postAfterHit;

  always_comb begin
    trigHit      = active && !triggered && trigIn && !armPulse;
    preEff       = (fillCnt < preReg) ? fillCnt : preReg;
    postNeed     = CNT_W'(DEPTH) - {1'b0, preEff};
    postAfterHit = postNeed - CNT_W'(qualIn);
    strobe.clrPtr = armPulse;
    strobe.wrEn   = active && qualIn && !armPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      done       <= 1'b0;
      triggered  <= 1'b0;
      preReg     <= '0;
      fillCnt    <= '0;
      postLeft   <= '0;
      trigIdxReg <= '0;
    end else if (armPulse) begin
      active     <= 1'b1;
      done       <= 1'b0;
      triggered  <= 1'b0;
      preReg     <= preCount;
      fillCnt    <= '0;
      postLeft   <= '0;
      trigIdxReg <= '0;
    end else if (active) begin
      if (trigHit) begin
        triggered  <= 1'b1;
        trigIdxReg <= preEff;
        postLeft   <= postAfterHit;
        if (postAfterHit == '0) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else if (!triggered) begin
        if (qualIn && fillCnt != FILL_MAX) fillCnt <= fillCnt + 1'b1;
      end else if (qualIn) begin
        postLeft <= postLeft - 1'b1;
        if (postLeft == CNT_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign capActive = active;
  assign capDone   = done;
  assign trigIndex = trigIdxReg;
endmodule

// File: rtl/tcb_dpath.sv
module tcb_dpath
  import tcb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcb_strobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  wrPtr;
  logic [IDX_W-1:0]  physAddr;

  // When the window is complete, wrPtr points at the oldest sample.
  assign physAddr = rdAddr + wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN)                wrPtr <= '0;
    else if (strobe.clrPtr)   wrPtr <= '0;
    else if (strobe.wrEn)     wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrPtr] <= dataIn;
    rdData <= store[physAddr];
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armPulse,
  input  logic              trigIn,
  input  logic              qualIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  preCount,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              capActive,
  output logic              capDone,
  output logic [IDX_W-1:0]  trigIndex
);
  tcb_strobe_t strobe;
  logic        memWrite;

  assign memWrite = strobe.wrEn;

  tcb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .trigIn(trigIn),
    .qualIn(qualIn), .preCount(preCount), .strobe(strobe),
    .capActive(capActive), .capDone(capDone), .trigIndex(trigIndex)
  );

  tcb_dpath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             armPulse,
  input logic             capActive,
  input logic             capDone,
  input logic [IDX_W-1:0] trigIndex,
  input logic             memWrite
);
  a_r1_idle_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(capActive && capDone));

  a_r2_arm_starts: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |=> (capActive && !capDone));

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && !armPulse) |=> capDone);

  a_r5_no_write_unless_active: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> capActive);

  a_r10_trig_index_stable: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && !armPulse) |=> $stable(trigIndex));
endmodule

bind trace_capture_buf tcb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .armPulse(armPulse), .capActive(capActive),
  .capDone(capDone), .trigIndex(trigIndex), .memWrite(memWrite)
);

// File: tb/trace_capture_buf_test.sv
`timescale 1ns/1ps
module trace_capture_buf_test;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 8;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              armPulse = 1'b0, trigIn = 1'b0, qualIn = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [IDX_W-1:0]  preCount = '0, rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic              capActive, capDone;
  logic [IDX_W-1:0]  trigIndex;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] hist [4096];
  int seqVal = 0;

  always #5 clk = ~clk;

  trace_capture_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .trigIn(trigIn),
    .qualIn(qualIn), .dataIn(dataIn), .preCount(preCount), .rdAddr(rdAddr),
    .rdData(rdData), .capActive(capActive), .capDone(capDone),
    .trigIndex(trigIndex)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reads the whole window and compares with the last DEPTH qualified samples.
  task automatic checkWindow(input int total, input string req);
    int bad = 0;
    int firstAct = 0, firstExp = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rdAddr = IDX_W'(i);
      @(posedge clk);
      @(negedge clk);
      if (rdData !== hist[total - DEPTH + i]) begin
        if (bad == 0) begin firstAct = int'(rdData); firstExp = int'(hist[total - DEPTH + i]); end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  // One full capture: pre = requested count, nBefore = qualified samples before
  // the trigger, qualEvery = qualify period, trigOnQual = trigger cycle qualified.
  task automatic runCapture(input int pre, input int nBefore, input int qualEvery,
                            input bit trigOnQual, input bit changePre, input string tag);
    int qualSoFar = 0, qualBefore = 0, cyc = 0;
    bit fired = 0, finished = 0;
    int pe, total;
    @(negedge clk);
    preCount = IDX_W'(pre);
    armPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    armPulse = 1'b0;
    check(capActive && !capDone, {tag, " R2 arm"}, {30'd0, capActive, capDone}, 2);
    if (changePre) preCount = IDX_W'(DEPTH - 1 - pre);  // R9: must not matter
    while (cyc < 5000) begin
      bit q, t;
      if (capDone) begin finished = 1; break; end
      q = (cyc % qualEvery) == 0;
      t = !fired && (qualSoFar == nBefore) && (q == trigOnQual);
      if (fired && (cyc % 37) == 0) t = 1'b1;   // R8: late triggers ignored
      if (!fired && t) begin fired = 1; qualBefore = qualSoFar; end
      seqVal++;
      dataIn = DATA_W'(seqVal);
      qualIn = q;
      trigIn = t;
      if (q) begin hist[qualSoFar] = DATA_W'(seqVal); qualSoFar++; end
      @(posedge clk);
      @(negedge clk);
      qualIn = 1'b0;
      trigIn = 1'b0;
      cyc++;
    end
    pe = (qualBefore < pre) ? qualBefore : pre;
    total = qualSoFar;
    check(finished == 1, {tag, " R5 done asserted"}, finished, 1);
    check(!capActive, {tag, " R5 active low when done"}, int'(capActive), 0);
    check(int'(trigIndex) == pe, {tag, " R10 R6 trigger index"}, int'(trigIndex), pe);
    check(total - qualBefore == DEPTH - pe, {tag, " R5 post sample count"},
          total - qualBefore, DEPTH - pe);
    checkWindow(total, {tag, " R4 R7 R3 window contents"});
    // Further qualified data and triggers after done must not change anything.
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      seqVal++;
      dataIn = DATA_W'(seqVal);
      qualIn = 1'b1;
      trigIn = (k % 3) == 0;
    end
    @(negedge clk);
    qualIn = 1'b0;
    trigIn = 1'b0;
    check(capDone && int'(trigIndex) == pe, {tag, " R5 R8 state held after done"},
          int'(trigIndex), pe);
    checkWindow(total, {tag, " R5 no write after done"});
  endtask

  task automatic testReset();
    check(!capActive, "R1 active after reset", int'(capActive), 0);
    check(!capDone, "R1 done after reset", int'(capDone), 0);
  endtask

  task automatic testIdleTrigger();
    @(negedge clk);
    trigIn = 1'b1; qualIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trigIn = 1'b0; qualIn = 1'b0;
    check(!capActive && !capDone, "R8 trigger while idle", {30'd0, capActive, capDone}, 0);
  endtask

  task automatic testRearm();
    @(negedge clk);
    preCount = 8'd10;
    armPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    armPulse = 1'b0;
    qualIn = 1'b1; trigIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    qualIn = 1'b0; trigIn = 1'b0;
    armPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    armPulse = 1'b0;
    check(capActive && !capDone, "R2 rearm mid-capture", {30'd0, capActive, capDone}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleTrigger();
    testRearm();
    runCapture(0,   0,   1, 1'b1, 1'b0, "pre0");
    runCapture(DEPTH - 1, 300, 1, 1'b1, 1'b0, "preMax");
    runCapture(100, 40,  3, 1'b1, 1'b0, "early");
    runCapture(128, 500, 2, 1'b0, 1'b1, "unqualTrig");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule